// File: doc/BRIEF.md
# NaN Result Selector for a Three-Source Fused Multiply-Add Stage

This block sits in front of the arithmetic datapath of a three-source fused multiply-add unit. Each source is an 82-bit register-format value: a sign bit at [81], a 17-bit exponent at [80:64], and a 64-bit significand at [63:0] whose bit 63 is an explicit integer bit. Bit 62 is the top fraction bit. When an arithmetic operation sees a NaN on any source, the block chooses the NaN that becomes the result. It makes that NaN quiet and raises an invalid-operation indication when any source is a signaling NaN. The arithmetic for non-NaN inputs happens elsewhere. A result-valid qualifier tells the downstream datapath whether this stage supplied the result.

An operation-class input selects one of three behaviours. Arithmetic operations run the NaN selection. Bit-manipulation (non-arithmetic) operations bypass exception reporting entirely. Floating-point-to-integer conversions take their source from the second operand slot (f2). An invalid conversion delivers the integer indefinite when the invalid trap is disabled.

Both sides of the block use valid/ready handshakes with one output register. A transfer on the input side happens in a cycle where `in_valid` and `in_ready` are both high. Its result appears on the output one clock later. The output holds its value for as long as `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A stalled output therefore blocks new input, and no data is dropped or overwritten.

Top module: `nan_prop_sel`

## Requirements
- R1: A source is a NaN when its exponent field [80:64] is all ones (0x1FFFF) and its fraction bits [62:0] are not all zero. A source with an all-ones exponent and a zero fraction is an infinity and is never treated as a NaN.
- R2: A NaN is signaling when bit 62 is 0 and quiet when bit 62 is 1. The delivered NaN always has bit 62 set. Its sign, integer bit 63, exponent and bits [61:0] are copied unchanged from the chosen source.
- R3: For an arithmetic operation (`op_class` = 2'b00) with at least one NaN source, the result is taken from the first NaN found in the fixed order f4, f2, f3, and `out_res_valid` is 1.
- R4: For an arithmetic operation, `out_invalid` is 1 exactly when at least one of the three sources is a signaling NaN, whichever source supplied the result. Quiet NaNs alone leave it at 0.
- R5: For a non-arithmetic operation (`op_class` = 2'b01, and also the reserved code 2'b11), `out_invalid`, `out_res_valid` and `out_result` are all 0, whatever the sources hold.
- R6: For an arithmetic operation with no NaN source, `out_res_valid` and `out_invalid` are 0 and `out_result` is 0.
- R7: For a conversion (`op_class` = 2'b10) whose f2 source is a NaN or an infinity while `inv_trap_en` is 0, `out_invalid` and `out_res_valid` are 1. `out_result` is the integer indefinite: sign 0, exponent 0x1003E, significand 0x8000_0000_0000_0000. This holds whether `cvt_unsigned` is 0 or 1.
- R8: For a conversion whose f2 source is a NaN or an infinity while `inv_trap_en` is 1, `out_invalid` is 1, `out_res_valid` is 0 and `out_result` is 0. A conversion of any other f2 value gives 0 on all three outputs, and f3 and f4 have no effect on a conversion.
- R9: An input transfer appears on the outputs one clock later. `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is 1 and `out_ready` is 0, every output stays unchanged. `out_valid` falls after a drain cycle with no new transfer.
- R10: While `rst_n` is low, `out_valid`, `out_res_valid`, `out_invalid` and `out_result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Block can accept an operation this cycle |
| op_class | input | 2 | 00 arithmetic, 01 non-arithmetic, 10 conversion to integer, 11 treated as non-arithmetic |
| cvt_unsigned | input | 1 | Conversion target is unsigned (result is the same) |
| inv_trap_en | input | 1 | Invalid-operation trap enabled |
| src_f2 | input | 82 | Source in the f2 field |
| src_f3 | input | 82 | Source in the f3 field |
| src_f4 | input | 82 | Source in the f4 field |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Downstream accepts the output this cycle |
| out_result | output | 82 | Selected quiet NaN, integer indefinite, or 0 |
| out_res_valid | output | 1 | This stage supplied the result |
| out_invalid | output | 1 | Invalid-operation indication |

## Verification
Every result is due exactly one clock after the cycle where `in_valid` and `in_ready` were both high. It then stays put for as long as `out_ready` holds it back. The bench drives inputs and samples outputs on the falling edge. Its reference model advances one state per clock from the same handshake rule, so the expected output register is compared with the design on every cycle and never a cycle early or late. `in_ready` is checked against the model's own occupancy in the same sampling slot, before the bench changes `out_ready`.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

  typedef enum logic [1:0] {
    OPC_ARITH = 2'b00,
    OPC_BITOP = 2'b01,
    OPC_CVTI  = 2'b10,
    OPC_RSVD  = 2'b11
  } opc_e;

  // Number of sources examined, listed in priority order (f4, f2, f3).
  localparam int NSRC = 3;

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify #(
  parameter int EXP_W = 17,
  parameter int SIG_W = 64
) (
  input  logic [EXP_W-1:0] exp_f,
  input  logic [SIG_W-2:0] frac_f,
  output logic             is_nan,
  output logic             is_snan,
  output logic             is_inf
);
  localparam int QBIT = SIG_W - 2;

  logic exp_top;
  logic frac_any;

  assign exp_top  = &exp_f;
  assign frac_any = |frac_f;

  assign is_nan  = exp_top & frac_any;
  assign is_inf  = exp_top & ~frac_any;
  assign is_snan = is_nan & ~frac_f[QBIT];

  always_comb begin
    assert_inf_excl_nan_R1: assert (!(is_inf && is_nan));
  end
endmodule

// File: rtl/nanp_pick.sv
module nanp_pick
  import nanp_pkg::*;
#(
  parameter int EXP_W = 17,
  parameter int SIG_W = 64,
  localparam int W = 1 + EXP_W + SIG_W
) (
  input  logic [W-1:0] ops   [NSRC],
  input  logic         nan_v [NSRC],
  input  logic         snan_v[NSRC],
  output logic [W-1:0] quiet_res,
  output logic         any_nan,
  output logic         any_snan
);
  localparam int QBIT = SIG_W - 2;

  logic [W-1:0] chosen;

  always_comb begin
    chosen   = '0;
    any_nan  = 1'b0;
    any_snan = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (nan_v[i]) begin
        chosen  = ops[i];
        any_nan = 1'b1;
      end
      any_snan = any_snan | snan_v[i];
    end
  end

  always_comb begin
    quiet_res       = chosen;
    quiet_res[QBIT] = 1'b1;
  end

  always_comb begin
    assert_snan_means_nan_R4: assert (!any_snan || any_nan);
  end
endmodule

// File: rtl/nanp_cvt.sv
module nanp_cvt #(
  parameter int EXP_W = 17,
  parameter int SIG_W = 64,
  localparam int W = 1 + EXP_W + SIG_W
) (
  input  logic         src_nan,
  input  logic         src_inf,
  input  logic         trap_en,
  output logic         cv_invalid,
  output logic         cv_res_valid,
  output logic [W-1:0] cv_result
);
  localparam int            BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] IND_EXP = EXP_W'(BIAS + SIG_W - 1);
  localparam logic [W-1:0]  IND_VAL  = {1'b0, IND_EXP, 1'b1, {(SIG_W-1){1'b0}}};

  logic bad_src;

  assign bad_src      = src_nan | src_inf;
  assign cv_invalid   = bad_src;
  assign cv_res_valid = bad_src & ~trap_en;
  assign cv_result    = cv_res_valid ? IND_VAL : '0;
endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel
  import nanp_pkg::*;
#(
  parameter int EXP_W = 17,
  parameter int SIG_W = 64,
  localparam int W = 1 + EXP_W + SIG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [1:0]   op_class,
  input  logic         cvt_unsigned,
  input  logic         inv_trap_en,
  input  logic [W-1:0] src_f2,
  input  logic [W-1:0] src_f3,
  input  logic [W-1:0] src_f4,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_res_valid,
  output logic         out_invalid
);
  localparam int EXP_LO = SIG_W;
  localparam int EXP_HI = SIG_W + EXP_W - 1;
  localparam int QBIT   = SIG_W - 2;
  localparam logic [W-1:0] IND_VAL =
    {1'b0, EXP_W'((1 << (EXP_W - 1)) - 1 + SIG_W - 1), 1'b1, {(SIG_W-1){1'b0}}};

  opc_e opc;
  assign opc = opc_e'(op_class);

  // Sources in priority order: index 0 = f4, 1 = f2, 2 = f3.
  logic [W-1:0] ops    [NSRC];
  logic         nan_v  [NSRC];
  logic         snan_v [NSRC];
  logic         inf_v  [NSRC];

  assign ops[0] = src_f4;
  assign ops[1] = src_f2;
  assign ops[2] = src_f3;

  for (genvar g = 0; g < NSRC; g++) begin : g_cls
    nanp_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cls (
      .exp_f  (ops[g][EXP_HI:EXP_LO]),
      .frac_f (ops[g][SIG_W-2:0]),
      .is_nan (nan_v[g]),
      .is_snan(snan_v[g]),
      .is_inf (inf_v[g])
    );
  end

  logic [W-1:0] quiet_res;
  logic         any_nan;
  logic         any_snan;

  nanp_pick #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_pick (
    .ops      (ops),
    .nan_v    (nan_v),
    .snan_v   (snan_v),
    .quiet_res(quiet_res),
    .any_nan  (any_nan),
    .any_snan (any_snan)
  );

  logic         cv_invalid;
  logic         cv_res_valid;
  logic [W-1:0] cv_result;

  nanp_cvt #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_cvt (
    .src_nan     (nan_v[1]),
    .src_inf     (inf_v[1]),
    .trap_en     (inv_trap_en),
    .cv_invalid  (cv_invalid),
    .cv_res_valid(cv_res_valid),
    .cv_result   (cv_result)
  );

  logic [W-1:0] nx_result;
  logic         nx_res_valid;
  logic         nx_invalid;

  always_comb begin
    nx_result    = '0;
    nx_res_valid = 1'b0;
    nx_invalid   = 1'b0;
    unique case (opc)
      OPC_ARITH: begin
        nx_result    = any_nan ? quiet_res : '0;
        nx_res_valid = any_nan;
        nx_invalid   = any_snan;
      end
      OPC_CVTI: begin
        nx_result    = cv_result;
        nx_res_valid = cv_res_valid;
        nx_invalid   = cv_invalid;
      end
      default: ;
    endcase
  end

  logic take;
  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_res_valid <= 1'b0;
      out_invalid   <= 1'b0;
    end else if (take) begin
      out_valid     <= 1'b1;
      out_result    <= nx_result;
      out_res_valid <= nx_res_valid;
      out_invalid   <= nx_invalid;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_invalid) && $stable(out_res_valid));

  assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid);

  assert_quiet_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_res_valid && (&out_result[EXP_HI:EXP_LO]) |-> out_result[QBIT]);

  assert_bitop_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_class[0] |=> !out_invalid && !out_res_valid);

  assert_cvt_unsigned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_class == 2'b10 && cvt_unsigned && !inv_trap_en
      && (&src_f2[EXP_HI:EXP_LO])
    |=> out_res_valid && out_invalid && out_result == IND_VAL);

  assert_trap_no_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_class == 2'b10 && inv_trap_en |=> !out_res_valid);
endmodule

// File: tb/nan_prop_sel_tb.sv
`timescale 1ns/1ps
module nan_prop_sel_tb;
  localparam int W = 82;
  localparam logic [16:0] EMAX = 17'h1FFFF;
  localparam logic [W-1:0] IND = {1'b0, 17'h1003E, 1'b1, 63'h0};
  localparam logic [W-1:0] ONE = {1'b0, 17'h0FFFF, 1'b1, 63'h0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] op_class = 2'b00;
  logic cvt_unsigned = 1'b0, inv_trap_en = 1'b0;
  logic [W-1:0] src_f2 = '0, src_f3 = '0, src_f4 = '0;
  logic out_valid, out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic out_res_valid, out_invalid;

  always #4 clk = ~clk;

  nan_prop_sel u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_class(op_class), .cvt_unsigned(cvt_unsigned), .inv_trap_en(inv_trap_en),
    .src_f2(src_f2), .src_f3(src_f3), .src_f4(src_f4),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_res_valid(out_res_valid), .out_invalid(out_invalid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic         m_valid = 1'b0;
  logic [W-1:0] m_res = '0;
  logic         m_rv = 1'b0, m_inv = 1'b0;
  string        m_tag = "R10";

  function automatic logic f_nan(input logic [W-1:0] x);
    return (x[80:64] == EMAX) && (x[62:0] != 63'h0);
  endfunction
  function automatic logic f_inf(input logic [W-1:0] x);
    return (x[80:64] == EMAX) && (x[62:0] == 63'h0);
  endfunction
  function automatic logic f_snan(input logic [W-1:0] x);
    return f_nan(x) && !x[62];
  endfunction

  function automatic logic [W-1:0] qn(input logic s, input logic [61:0] p);
    return {s, EMAX, 1'b1, 1'b1, p};
  endfunction
  function automatic logic [W-1:0] sn(input logic s, input logic [61:0] p);
    return {s, EMAX, 1'b1, 1'b0, p};
  endfunction
  function automatic logic [W-1:0] inf(input logic s);
    return {s, EMAX, 1'b1, 63'h0};
  endfunction

  task automatic ref_calc(input logic [1:0] opc, input logic trap,
                          input logic [W-1:0] a2, input logic [W-1:0] a3,
                          input logic [W-1:0] a4,
                          output logic [W-1:0] res, output logic rv, output logic inv);
    res = '0; rv = 1'b0; inv = 1'b0;
    if (opc == 2'b00) begin
      if (f_nan(a4))      begin res = a4; rv = 1'b1; end
      else if (f_nan(a2)) begin res = a2; rv = 1'b1; end
      else if (f_nan(a3)) begin res = a3; rv = 1'b1; end
      if (rv) res[62] = 1'b1;
      inv = f_snan(a2) || f_snan(a3) || f_snan(a4);
    end else if (opc == 2'b10) begin
      if (f_nan(a2) || f_inf(a2)) begin
        inv = 1'b1;
        if (!trap) begin rv = 1'b1; res = IND; end
      end
    end
  endtask

  task automatic compare();
    logic exp_rdy;
    exp_rdy = !m_valid || out_ready;
    checks++;
    if (in_ready !== exp_rdy) begin
      errors++;
      $display("FAIL R9 in_ready: actual %b expected %b", in_ready, exp_rdy);
    end
    checks++;
    if (out_valid !== m_valid) begin
      errors++;
      $display("FAIL R9 out_valid (%s): actual %b expected %b", m_tag, out_valid, m_valid);
    end else if (m_valid && (out_result !== m_res || out_res_valid !== m_rv
                             || out_invalid !== m_inv)) begin
      errors++;
      $display("FAIL %s: actual res=%h rv=%b inv=%b expected res=%h rv=%b inv=%b",
               m_tag, out_result, out_res_valid, out_invalid, m_res, m_rv, m_inv);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [1:0] opc,
                      input logic uns, input logic trap,
                      input logic [W-1:0] a2, input logic [W-1:0] a3,
                      input logic [W-1:0] a4, input logic rdy);
    logic accept;
    @(negedge clk);
    compare();
    in_valid = v; op_class = opc; cvt_unsigned = uns; inv_trap_en = trap;
    src_f2 = a2; src_f3 = a3; src_f4 = a4; out_ready = rdy;
    accept = v && (!m_valid || rdy);
    if (accept) begin
      m_valid = 1'b1;
      m_tag   = tag;
      ref_calc(opc, trap, a2, a3, a4, m_res, m_rv, m_inv);
    end else if (rdy) begin
      m_valid = 1'b0;
    end
  endtask

  function automatic logic [W-1:0] rnd_op();
    logic [61:0] p;
    p = {$urandom(), $urandom()};
    if (p == 62'h0) p = 62'h1;
    case ($urandom_range(0, 4))
      0: return {$urandom_range(0, 1) == 1, 17'($urandom()), 1'b1, 31'($urandom()), 32'($urandom())};
      1: return inf($urandom_range(0, 1) == 1);
      2: return qn($urandom_range(0, 1) == 1, p);
      3: return sn($urandom_range(0, 1) == 1, p);
      default: return {1'b0, EMAX, 1'b0, 1'b0, 62'h1};
    endcase
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (out_valid !== 1'b0 || out_result !== '0 || out_res_valid !== 1'b0
        || out_invalid !== 1'b0) begin
      errors++;
      $display("FAIL R10 reset: actual v=%b res=%h rv=%b inv=%b expected all zero",
               out_valid, out_result, out_res_valid, out_invalid);
    end
    rst_n = 1'b1;

    // R1: infinities and numbers are not NaNs
    step("R1", 1, 2'b00, 0, 0, inf(0), inf(1), ONE, 1);
    // R1/R2: minimal signaling NaN with integer bit clear becomes quiet
    step("R2", 1, 2'b00, 0, 0, {1'b1, EMAX, 1'b0, 1'b0, 62'h1}, ONE, inf(0), 1);
    // R3: priority f4 over f2 over f3
    step("R3", 1, 2'b00, 0, 0, qn(0, 62'h22), qn(1, 62'h33), qn(0, 62'h44), 1);
    step("R3", 1, 2'b00, 0, 0, sn(1, 62'h22), qn(0, 62'h33), ONE, 1);
    step("R3", 1, 2'b00, 0, 0, inf(1), sn(0, 62'h33), ONE, 1);
    // R4: quiet only -> no invalid; signaling in unselected f3 -> invalid
    step("R4", 1, 2'b00, 0, 0, qn(0, 62'h5), qn(0, 62'h6), ONE, 1);
    step("R4", 1, 2'b00, 0, 0, ONE, sn(0, 62'h7), qn(1, 62'h8), 1);
    // R5: non-arithmetic and reserved classes report nothing
    step("R5", 1, 2'b01, 0, 0, sn(0, 62'h9), sn(1, 62'hA), sn(0, 62'hB), 1);
    step("R5", 1, 2'b11, 0, 0, sn(0, 62'h9), qn(1, 62'hA), sn(0, 62'hB), 1);
    // R6: no NaN
    step("R6", 1, 2'b00, 0, 0, ONE, ONE, {1'b1, 17'h00001, 64'h8000_0000_0000_0001}, 1);
    // R7: invalid conversion, trap disabled, signed and unsigned
    step("R7", 1, 2'b10, 0, 0, qn(1, 62'h1), ONE, ONE, 1);
    step("R7", 1, 2'b10, 1, 0, sn(0, 62'h3), ONE, ONE, 1);
    step("R7", 1, 2'b10, 1, 0, inf(1), ONE, ONE, 1);
    // R8: trap enabled; finite source; f3/f4 NaNs ignored by conversion
    step("R8", 1, 2'b10, 0, 1, qn(0, 62'h1), ONE, ONE, 1);
    step("R8", 1, 2'b10, 0, 0, ONE, sn(0, 62'h1), sn(1, 62'h2), 1);
    // R9: back-pressure holds output, bubble drains it
    step("R9", 1, 2'b00, 0, 0, qn(0, 62'h77), ONE, ONE, 0);
    step("R9", 1, 2'b00, 0, 0, ONE, ONE, sn(1, 62'h99), 0);
    step("R9", 1, 2'b00, 0, 0, ONE, ONE, sn(1, 62'h99), 0);
    step("R9", 1, 2'b00, 0, 0, ONE, ONE, sn(1, 62'h99), 1);
    step("R9", 0, 2'b00, 0, 0, ONE, ONE, ONE, 1);
    step("R9", 0, 2'b00, 0, 0, ONE, ONE, ONE, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] oc;
      string t;
      oc = 2'($urandom_range(0, 3));
      t = (oc == 2'b00) ? "R3" : (oc == 2'b10) ? "R7" : "R5";
      step(t, $urandom_range(0, 3) != 0, oc, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, rnd_op(), rnd_op(), rnd_op(),
           $urandom_range(0, 3) != 0);
    end
    step("R9", 0, 2'b00, 0, 0, ONE, ONE, ONE, 1);
    @(negedge clk);
    compare();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule